// File: doc/BRIEF.md
# Two-Level Descriptor Cookie Translator

This block turns a packed 20-bit descriptor cookie into the 64-bit virtual address of a descriptor by walking two tables. The upper cookie field picks an entry in a primary page table held in an on-chip memory with a one-cycle read. That entry gives the physical base of a secondary page. The lower cookie field then picks one 8-byte slot in that page, which is read through a separate memory port whose latency is not fixed. The 8 bytes returned are the translation result.

Two primary-table layouts are supported and chosen per request. In page-aligned mode each primary slot is 32 bits wide and holds a page frame number that is shifted up by the page size. Two slots share one 64-bit memory word, and the lowest bit of the index picks the half. In full-address mode each primary slot is a whole 64-bit word holding the page base. The primary table size is a parameter (4096 or 8192 bytes). An index past the end of the table is reported as an error without any memory access. One translation is handled at a time.

Top module: `ckx_top`

## Requirements
- R1: After reset the block is idle: `ck_ready` is 1, `out_valid` is 0, and neither `pt_rd_en` nor `sm_rd_req` is asserted.
- R2: With `ck_aligned`=1 the primary index is cookie bits 19:9. The block reads 64-bit word index>>1 and takes bits 63:32 when index bit 0 is 1, bits 31:0 when it is 0. The page base is that 32-bit value shifted left by 12 and zero-extended.
- R3: With `ck_aligned`=0 the block reads 64-bit word index (cookie bits 19:9) directly, and the page base is the whole 64-bit word.
- R4: Each in-range translation issues exactly one `sm_rd_req` pulse, with `sm_rd_addr` equal to page base plus cookie bits 8:0 times 8.
- R5: `out_va` equals the `sm_rd_data` that arrives with `sm_rd_vld`, whatever the number of cycles between request and data.
- R6: An index of PT_BYTES/4 or more in aligned mode, or of PT_BYTES/8 or more in full-address mode, gives `out_err`=1 with `out_va`=0. Neither a primary read nor a secondary read is issued.
- R7: Only one translation is in flight. `ck_ready` is 0 from the cycle after acceptance until the result has been taken on the output.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_va` and `out_err` stay unchanged.
- R9: The mode input is sampled only when a cookie is accepted. A change of `ck_aligned` during a walk does not affect that walk's result.
- R10: Each in-range translation issues exactly one single-cycle primary read.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ck_valid | input | 1 | Cookie request valid |
| ck_ready | output | 1 | Block idle and able to take a cookie |
| ck_cookie | input | 20 | Packed cookie: index in 19:9, page offset in 8:0 |
| ck_aligned | input | 1 | 1: 32-bit page-aligned primary slots; 0: 64-bit full-address slots |
| pt_rd_en | output | 1 | Primary table read strobe |
| pt_rd_addr | output | 9 | Primary table 64-bit word index |
| pt_rd_data | input | 64 | Primary table word, valid the cycle after the strobe |
| sm_rd_req | output | 1 | Secondary read request, one-cycle pulse |
| sm_rd_addr | output | 64 | Secondary entry byte address |
| sm_rd_vld | input | 1 | Secondary read data valid |
| sm_rd_data | input | 64 | Secondary read data |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken by consumer |
| out_va | output | 64 | Translated descriptor address |
| out_err | output | 1 | Index was beyond the primary table |

## Verification
A wrong half-select or a wrong index shift shows up at once on `sm_rd_addr`, at the single request pulse of that walk. This happens before any data returns, so the bench compares the captured request address as well as the final result. A controller that loses its place either leaves `ck_ready` low past the bench's wait limit, or raises `out_valid` with a stale value. A range check that is off by one appears only at the last legal index and the first illegal index in each mode. For that reason those boundaries are driven directly, and the bench counts the memory strobes per walk.

// File: rtl/ckx_pkg.sv
// Shared types for the cookie translator.
package ckx_pkg;
    // Walk controller states, in walk order.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PTRD   = 3'd1,
        ST_PTCAP  = 3'd2,
        ST_SMREQ  = 3'd3,
        ST_SMWAIT = 3'd4,
        ST_DONE   = 3'd5
    } ckx_state_e;

    // log2 of the secondary entry size in bytes (8-byte entries).
    localparam int unsigned ENTRY_SHIFT = 3;
endpackage

// File: rtl/ckx_index.sv
// ckx_index: splits a latched cookie into primary word address, half
// select, page offset and an in-range flag for the chosen slot layout.
// Assumes PT_BYTES is a multiple of 8 and the index field is wide enough
// to address every 32-bit slot of the table.
module ckx_index #(
    parameter int unsigned CK_W     = 20,
    parameter int unsigned OFF_W    = 9,
    parameter int unsigned PT_BYTES = 4096,
    parameter int unsigned WA_W     = 9
) (
    input  logic [CK_W-1:0]  cookie,
    input  logic             aligned,
    output logic [WA_W-1:0]  word_addr,
    output logic             hi_half,
    output logic [OFF_W-1:0] offset,
    output logic             in_range
);
    localparam int unsigned IDX_W  = CK_W - OFF_W;
    localparam int unsigned SLOTS4 = PT_BYTES / 4;
    localparam int unsigned SLOTS8 = PT_BYTES / 8;

    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   idx_ext;

    // Field split and layout-dependent addressing.
    always_comb begin
        idx     = cookie[CK_W-1:OFF_W];
        offset  = cookie[OFF_W-1:0];
        idx_ext = {1'b0, idx};
        if (aligned) begin
            in_range  = idx_ext < (IDX_W+1)'(SLOTS4);
            word_addr = WA_W'(idx >> 1);
            hi_half   = idx[0];
        end else begin
            in_range  = idx_ext < (IDX_W+1)'(SLOTS8);
            word_addr = WA_W'(idx);
            hi_half   = 1'b0;
        end
    end
endmodule

// File: rtl/ckx_base.sv
// ckx_base: forms the secondary entry byte address from a primary table
// word. Aligned layout: the selected 32-bit half is a frame number shifted
// by PAGE_SHIFT. Full layout: the word is the base. The offset is scaled
// by the 8-byte entry size. Assumes AW >= 32 + PAGE_SHIFT.
module ckx_base
    import ckx_pkg::*;
#(
    parameter int unsigned AW         = 64,
    parameter int unsigned OFF_W      = 9,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic [63:0]      pt_word,
    input  logic             aligned,
    input  logic             hi_half,
    input  logic [OFF_W-1:0] offset,
    output logic [AW-1:0]    entry_addr
);
    logic [31:0]   frame;
    logic [AW-1:0] page_base;

    // Page base selection and entry offset addition.
    always_comb begin
        frame      = hi_half ? pt_word[63:32] : pt_word[31:0];
        page_base  = aligned ? (AW'(frame) << PAGE_SHIFT) : AW'(pt_word);
        entry_addr = page_base + (AW'(offset) << ENTRY_SHIFT);
    end
endmodule

// File: rtl/ckx_ctrl.sv
// ckx_ctrl: walk sequencer. Accepts one cookie when idle, issues one
// primary read, one secondary request, waits any time for secondary data,
// then holds the result until taken. Out-of-range indices skip both reads.
// Assumes primary data is valid the cycle after the read strobe.
module ckx_ctrl
    import ckx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_range,
    input  logic sm_vld,
    input  logic out_ready,
    output logic in_ready,
    output logic accept,
    output logic pt_en,
    output logic cap_base,
    output logic sm_req,
    output logic cap_result,
    output logic res_valid,
    output logic res_err
);
    ckx_state_e state;

    // State register and error flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            res_err <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (in_valid) begin
                    state   <= ST_PTRD;
                    res_err <= 1'b0;
                end
                ST_PTRD: if (in_range) begin
                    state <= ST_PTCAP;
                end else begin
                    state   <= ST_DONE;
                    res_err <= 1'b1;
                end
                ST_PTCAP:  state <= ST_SMREQ;
                ST_SMREQ:  state <= ST_SMWAIT;
                ST_SMWAIT: if (sm_vld) state <= ST_DONE;
                ST_DONE:   if (out_ready) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Strobes and enables decoded from the state.
    always_comb begin
        in_ready   = (state == ST_IDLE);
        accept     = (state == ST_IDLE) && in_valid;
        pt_en      = (state == ST_PTRD) && in_range;
        cap_base   = (state == ST_PTCAP);
        sm_req     = (state == ST_SMREQ);
        cap_result = (state == ST_SMWAIT) && sm_vld;
        res_valid  = (state == ST_DONE);
    end
endmodule

// File: rtl/ckx_top.sv
// ckx_top: two-level descriptor cookie translator. Latches the cookie
// and layout mode on acceptance, walks primary then secondary memory,
// and presents the 64-bit result with an out-of-range error flag.
// Assumes a one-cycle primary read and a secondary port that answers
// each request with exactly one data-valid pulse.
module ckx_top #(
    parameter int unsigned CK_W       = 20,
    parameter int unsigned OFF_W      = 9,
    parameter int unsigned AW         = 64,
    parameter int unsigned PT_BYTES   = 4096,
    parameter int unsigned PAGE_SHIFT = 12,
    localparam int unsigned PT_WORDS  = PT_BYTES / 8,
    localparam int unsigned WA_W      = $clog2(PT_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ck_valid,
    output logic            ck_ready,
    input  logic [CK_W-1:0] ck_cookie,
    input  logic            ck_aligned,
    output logic            pt_rd_en,
    output logic [WA_W-1:0] pt_rd_addr,
    input  logic [63:0]     pt_rd_data,
    output logic            sm_rd_req,
    output logic [AW-1:0]   sm_rd_addr,
    input  logic            sm_rd_vld,
    input  logic [63:0]     sm_rd_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [AW-1:0]   out_va,
    output logic            out_err
);
    logic [CK_W-1:0]  cookie_q;
    logic             aligned_q;
    logic [AW-1:0]    entry_q;
    logic [AW-1:0]    va_q;
    logic [WA_W-1:0]  word_addr;
    logic             hi_half;
    logic [OFF_W-1:0] offset;
    logic             in_range;
    logic [AW-1:0]    entry_addr;
    logic             accept;
    logic             cap_base;
    logic             cap_result;

    ckx_index #(
        .CK_W(CK_W), .OFF_W(OFF_W), .PT_BYTES(PT_BYTES), .WA_W(WA_W)
    ) u_index (
        .cookie(cookie_q), .aligned(aligned_q), .word_addr(word_addr),
        .hi_half(hi_half), .offset(offset), .in_range(in_range)
    );

    ckx_base #(
        .AW(AW), .OFF_W(OFF_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_base (
        .pt_word(pt_rd_data), .aligned(aligned_q), .hi_half(hi_half),
        .offset(offset), .entry_addr(entry_addr)
    );

    ckx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(ck_valid), .in_range(in_range),
        .sm_vld(sm_rd_vld), .out_ready(out_ready), .in_ready(ck_ready),
        .accept(accept), .pt_en(pt_rd_en), .cap_base(cap_base),
        .sm_req(sm_rd_req), .cap_result(cap_result), .res_valid(out_valid),
        .res_err(out_err)
    );

    // Request capture: cookie and layout mode are frozen for the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cookie_q  <= '0;
            aligned_q <= 1'b0;
        end else if (accept) begin
            cookie_q  <= ck_cookie;
            aligned_q <= ck_aligned;
        end
    end

    // Secondary entry address captured from the primary read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else if (cap_base) begin
            entry_q <= entry_addr;
        end
    end

    // Result register: cleared per walk, loaded from secondary data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q <= '0;
        end else if (accept) begin
            va_q <= '0;
        end else if (cap_result) begin
            va_q <= AW'(sm_rd_data);
        end
    end

    assign pt_rd_addr = word_addr;
    assign sm_rd_addr = entry_q;
    assign out_va     = va_q;
endmodule

// File: rtl/ckx_props.sv
// ckx_props: protocol and ordering properties of the translator ports.
module ckx_props #(
    parameter int unsigned AW   = 64,
    parameter int unsigned WA_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ck_valid,
    input logic            ck_ready,
    input logic            pt_rd_en,
    input logic [WA_W-1:0] pt_rd_addr,
    input logic            sm_rd_req,
    input logic            out_valid,
    input logic            out_ready,
    input logic [AW-1:0]   out_va,
    input logic            out_err
);
    // R7: accepted cookie blocks further input next cycle.
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        ck_valid && ck_ready |=> !ck_ready);

    // R7: while ready, no walk activity or result is pending.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ck_ready |-> !out_valid && !sm_rd_req && !pt_rd_en);

    // R8: a stalled result holds value and flag.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_va) && $stable(out_err));

    // R4: secondary request is a single-cycle pulse.
    a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        sm_rd_req |=> !sm_rd_req);

    // R10: primary read strobe is a single-cycle pulse.
    a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |=> !pt_rd_en);

    // R6: an error result coincides with no memory activity.
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> !sm_rd_req && !pt_rd_en && (out_va == '0));

    // R10: the primary address is steady during its strobe cycle.
    a_r10_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_en |-> !$isunknown(pt_rd_addr));
endmodule

bind ckx_top ckx_props #(.AW(AW), .WA_W(WA_W)) u_props (
    .clk(clk), .rst_n(rst_n), .ck_valid(ck_valid), .ck_ready(ck_ready),
    .pt_rd_en(pt_rd_en), .pt_rd_addr(pt_rd_addr), .sm_rd_req(sm_rd_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_va(out_va),
    .out_err(out_err)
);

// File: tb/sim_ckx_top.sv
module sim_ckx_top;
    localparam int CLK_PERIOD = 10;
    localparam int PT_BYTES   = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ck_valid = 1'b0;
    logic        ck_ready;
    logic [19:0] ck_cookie = '0;
    logic        ck_aligned = 1'b0;
    logic        pt_rd_en;
    logic [8:0]  pt_rd_addr;
    logic [63:0] pt_rd_data;
    logic        sm_rd_req;
    logic [63:0] sm_rd_addr;
    logic        sm_rd_vld;
    logic [63:0] sm_rd_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_va;
    logic        out_err;

    int total = 0;
    int bad = 0;
    int pt_cnt = 0;
    int sm_cnt = 0;
    logic [63:0] last_sm_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckx_top #(.PT_BYTES(PT_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .ck_valid(ck_valid), .ck_ready(ck_ready),
        .ck_cookie(ck_cookie), .ck_aligned(ck_aligned), .pt_rd_en(pt_rd_en),
        .pt_rd_addr(pt_rd_addr), .pt_rd_data(pt_rd_data),
        .sm_rd_req(sm_rd_req), .sm_rd_addr(sm_rd_addr), .sm_rd_vld(sm_rd_vld),
        .sm_rd_data(sm_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_va(out_va), .out_err(out_err)
    );

    // 32-bit primary slot content by slot number.
    function automatic logic [31:0] slot32(input int unsigned i);
        return (i * 32'h9E37_79B1) ^ 32'h5A17_3C2D;
    endfunction

    // 64-bit primary word: two consecutive slots, higher one on top.
    function automatic logic [63:0] pt_word(input int unsigned w);
        return {slot32(2*w+1), slot32(2*w)};
    endfunction

    // Secondary memory content at a byte address.
    function automatic logic [63:0] sm_word(input logic [63:0] a);
        return {a[31:0], a[63:32]} ^ 64'hC3A5_0F1E_9B2D_4876;
    endfunction

    function automatic logic exp_err(input logic [19:0] ck, input logic al);
        int unsigned idx = int'(ck[19:9]);
        return al ? (idx >= PT_BYTES/4) : (idx >= PT_BYTES/8);
    endfunction

    function automatic logic [63:0] exp_addr(input logic [19:0] ck, input logic al);
        int unsigned idx = int'(ck[19:9]);
        logic [63:0] base;
        base = al ? ({32'h0, slot32(idx)} << 12) : pt_word(idx);
        return base + ({55'h0, ck[8:0]} << 3);
    endfunction

    // Primary memory model: one-cycle registered read.
    always @(posedge clk) begin
        if (pt_rd_en) begin
            pt_rd_data <= pt_word(int'(pt_rd_addr));
            pt_cnt     <= pt_cnt + 1;
        end
    end

    // Secondary memory model with random latency.
    logic [63:0] sm_a;
    int          sm_wait;
    logic        sm_busy = 1'b0;
    always @(posedge clk) begin
        sm_rd_vld <= 1'b0;
        if (!rst_n) begin
            sm_busy <= 1'b0;
        end else if (sm_rd_req) begin
            sm_a         <= sm_rd_addr;
            last_sm_addr <= sm_rd_addr;
            sm_cnt       <= sm_cnt + 1;
            sm_wait      <= int'($urandom % 7);
            sm_busy      <= 1'b1;
        end else if (sm_busy) begin
            if (sm_wait == 0) begin
                sm_rd_vld  <= 1'b1;
                sm_rd_data <= sm_word(sm_a);
                sm_busy    <= 1'b0;
            end else begin
                sm_wait <= sm_wait - 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One translation; flip toggles the mode input mid-walk, hold stalls output.
    task automatic xlate(input logic [19:0] ck, input logic al, input logic flip,
                         input int hold);
        int p0, s0, n;
        logic e;
        logic [63:0] ea, held;
        e  = exp_err(ck, al);
        ea = exp_addr(ck, al);
        @(negedge clk);
        check(ck_ready, "R7 ready before request", {63'h0, ck_ready}, 64'h1);
        p0 = pt_cnt; s0 = sm_cnt;
        ck_valid = 1'b1; ck_cookie = ck; ck_aligned = al;
        @(negedge clk);
        ck_valid = 1'b0;
        if (flip) ck_aligned = ~al;
        check(!ck_ready, "R7 busy after accept", {63'h0, ck_ready}, 64'h0);
        n = 0;
        while (!out_valid && n < 100) begin
            if (ck_ready) check(1'b0, "R7 ready during walk", 64'h1, 64'h0);
            @(negedge clk);
            n++;
        end
        check(out_valid, "R5 result arrives", {63'h0, out_valid}, 64'h1);
        held = out_va;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(out_valid && out_va == held, "R8 result held", out_va, held);
        end
        check(out_err == e, e ? "R6 error flag" : "R6 no error flag",
              {63'h0, out_err}, {63'h0, e});
        if (e) begin
            check(out_va == 64'h0, "R6 zero result", out_va, 64'h0);
            check(pt_cnt == p0 && sm_cnt == s0, "R6 no reads",
                  64'(pt_cnt - p0 + sm_cnt - s0), 64'h0);
        end else begin
            check(pt_cnt == p0 + 1, "R10 one primary read", 64'(pt_cnt - p0), 64'h1);
            check(sm_cnt == s0 + 1, "R4 one secondary request", 64'(sm_cnt - s0), 64'h1);
            check(last_sm_addr == ea, al ? "R2 R4 aligned entry address" :
                  "R3 R4 full entry address", last_sm_addr, ea);
            check(out_va == sm_word(ea), flip ? "R9 mode frozen result" : "R5 result",
                  out_va, sm_word(ea));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(ck_ready && !out_valid, "R7 idle after take",
              {62'h0, ck_ready, out_valid}, 64'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state.
        check(ck_ready && !out_valid && !pt_rd_en && !sm_rd_req, "R1 reset idle",
              {60'h0, ck_ready, out_valid, pt_rd_en, sm_rd_req}, 64'h8);
        // R2 lower and upper halves, last legal and first illegal slot.
        xlate({11'd0, 9'd0}, 1'b1, 1'b0, 0);
        xlate({11'd1, 9'd5}, 1'b1, 1'b0, 0);
        xlate({11'd1023, 9'd511}, 1'b1, 1'b0, 0);
        xlate({11'd1024, 9'd3}, 1'b1, 1'b0, 0);
        // R3 full-address boundaries.
        xlate({11'd0, 9'd511}, 1'b0, 1'b0, 0);
        xlate({11'd511, 9'd7}, 1'b0, 1'b0, 0);
        xlate({11'd512, 9'd0}, 1'b0, 1'b0, 0);
        xlate({11'd2047, 9'd1}, 1'b1, 1'b0, 0);
        // R9 mode flipped during the walk, both directions.
        xlate({11'd300, 9'd44}, 1'b1, 1'b1, 0);
        xlate({11'd301, 9'd45}, 1'b0, 1'b1, 0);
        // R8 output stall.
        xlate({11'd77, 9'd9}, 1'b1, 1'b0, 4);
        xlate({11'd900, 9'd2}, 1'b1, 1'b0, 3);
        for (int t = 0; t < 300; t++) begin
            xlate(20'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
                  int'($urandom % 3));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule